// File: doc/BRIEF.md
# Head-Marked Sequential Configuration Register

This block is the serial configuration store of one element in a tiled array. The configuration stream for a block of elements arrives on a single wire. The registers of that block fill one at a time rather than as one long chain. Each element's configuration word begins with a 1. When that 1 has travelled all the way to the head position, the register knows it is complete. It stops shifting and starts forwarding the stream to its neighbours, so the next register begins to fill.

The register has 24 bits by default. Bit 0 is the head and bit 23 is the tail. New bits enter at the tail and move one place toward the head on each enabled clock. The source of the shifted bit depends on the phase and on where the element sits:
- During the test phase the bit comes from the global line.
- During repair, or in the bottom row of a block, it comes from the west line.
- Otherwise it comes from the south line.

Once full, the element routes the stream to its north, south and east outputs, depending on its row and on whether it is an entry point. During repair it passes its own contents, head bit first, to the east neighbour.

Top module: `cfg_chain_reg`

## Requirements
- R1: Each enabled shift moves the word one place toward the head: new bit 23 is the selected input and new bit i is old bit i+1, for i from 0 to 22.
- R2: `full` equals bit 0 of the word. While `full` is 1, and neither `test_mode` nor `repair` is asserted, the word does not change.
- R3: While `en` is 0 the word does not change.
- R4: When `rst` is high at a clock edge, all bits of the word become 0, whatever the values of `en` and the other inputs.
- R5: The shift input is chosen as follows. If `test_mode` is 1, it is `glob_in`. Otherwise, if `bottom_row` or `repair` is 1, it is `sin_w`. Otherwise it is `sin_s`.
- R6: When `full` is 1, `sout_n` is chosen as follows. If `entry_pt` is 1, it is `glob_in`. Otherwise, if `bottom_row` is 1, it is `sin_w`. Otherwise it is `sin_s`. When `full` is 0, `sout_n` is 0.
- R7: When `full` is 1, `sout_s` is `sin_s` if `top_row` is 1, and `sin_n` otherwise. When `full` is 0, `sout_s` is 0.
- R8: When `repair` is 1, `sout_e` is the head bit (bit 0). Otherwise, `sout_e` is `sin_n` when `full` is 1, and 0 when `full` is 0.
- R9: While `en` is 1 and either `test_mode` or `repair` is 1, the word shifts even when `full` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous clear of the word |
| en | input | 1 | Shift enable |
| test_mode | input | 1 | Test phase: load from the global line |
| repair | input | 1 | Element is being reconfigured |
| bottom_row | input | 1 | Element is in the bottom row of its block |
| top_row | input | 1 | Element is in the top row of its block |
| entry_pt | input | 1 | Element is a block entry point |
| sin_s | input | 1 | Serial input from the south |
| sin_n | input | 1 | Serial input from the north |
| sin_w | input | 1 | Serial input from the west |
| glob_in | input | 1 | Global configuration line |
| sout_n | output | 1 | Serial output to the north |
| sout_s | output | 1 | Serial output to the south |
| sout_e | output | 1 | Serial output to the east |
| cfg | output | WIDTH | Stored configuration word |
| full | output | 1 | Head bit, 1 when the word is complete |

## Verification
A wrong bit in the word appears on `cfg` in the cycle after the faulty edge. A bit that is wrongly set or lost at the head flips `full` at once. That in turn opens or closes all three serial outputs in the same cycle, so a neighbour would start filling early or never start. During repair the head bit drives `sout_e` directly, so an error in shift order appears on the east output within at most 24 cycles. The bench compares every port against a queue model on every clock, so any such error is caught in the first cycle it becomes visible.

// File: rtl/cfg_chain_reg.sv
module cfg_chain_reg #(
  parameter int WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             test_mode,
  input  logic             repair,
  input  logic             bottom_row,
  input  logic             top_row,
  input  logic             entry_pt,
  input  logic             sin_s,
  input  logic             sin_n,
  input  logic             sin_w,
  input  logic             glob_in,
  output logic             sout_n,
  output logic             sout_s,
  output logic             sout_e,
  output logic [WIDTH-1:0] cfg,
  output logic             full
);

  localparam int TAIL = WIDTH - 1;

  logic shift_in;
  logic advance;
  logic north_pick;

  assign shift_in = test_mode ? glob_in : ((bottom_row || repair) ? sin_w : sin_s);
  assign full     = cfg[0];
  assign advance  = en && (!full || test_mode || repair);

  always_ff @(posedge clk) begin
    if (rst)
      cfg <= '0;
    else if (advance)
      cfg <= {shift_in, cfg[TAIL:1]};
  end

  assign north_pick = entry_pt ? glob_in : (bottom_row ? sin_w : sin_s);
  assign sout_n = full && north_pick;
  assign sout_s = full && (top_row ? sin_s : sin_n);
  assign sout_e = repair ? cfg[0] : (full && sin_n);

  assert_shift_toward_head_R1: assert property (@(posedge clk) disable iff (rst)
    (en && (!full || test_mode || repair)) |=> cfg[TAIL-1:0] == $past(cfg[TAIL:1]));

  assert_full_sticks_R2: assert property (@(posedge clk) disable iff (rst)
    (full && !test_mode && !repair) |=> (full && $stable(cfg)));

  assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cfg));

  assert_clear_on_reset_R4: assert property (@(posedge clk)
    rst |=> (cfg == '0));

  assert_quiet_until_full_R6: assert property (@(posedge clk) disable iff (rst)
    (!full && !repair) |-> (!sout_n && !sout_s && !sout_e));

endmodule

// File: tb/sim_cfg_chain_reg.sv
`timescale 1ns/100ps
module sim_cfg_chain_reg;
  localparam int W = 24;

  logic clk = 0;
  logic rst, en, test_mode, repair, bottom_row, top_row, entry_pt;
  logic sin_s, sin_n, sin_w, glob_in;
  logic sout_n, sout_s, sout_e, full;
  logic [W-1:0] cfg;

  int vectors = 0;
  int errors = 0;
  bit done = 0;
  bit q[$];

  always #2.5 clk = ~clk;

  cfg_chain_reg #(.WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .en(en), .test_mode(test_mode), .repair(repair),
    .bottom_row(bottom_row), .top_row(top_row), .entry_pt(entry_pt),
    .sin_s(sin_s), .sin_n(sin_n), .sin_w(sin_w), .glob_in(glob_in),
    .sout_n(sout_n), .sout_s(sout_s), .sout_e(sout_e), .cfg(cfg), .full(full));

  function automatic logic [W-1:0] model_word();
    logic [W-1:0] v;
    for (int i = 0; i < W; i++) v[i] = q[i];
    return v;
  endfunction

  task automatic compare();
    logic [W-1:0] ew;
    logic ef, en_, es, ee;
    ew  = model_word();
    ef  = q[0];
    en_ = ef ? (entry_pt ? glob_in : (bottom_row ? sin_w : sin_s)) : 1'b0;
    es  = ef ? (top_row ? sin_s : sin_n) : 1'b0;
    ee  = repair ? q[0] : (ef ? sin_n : 1'b0);
    vectors++;
    if (cfg !== ew) begin errors++; $display("FAIL R1 cfg got %h expected %h", cfg, ew); end
    if (full !== ef) begin errors++; $display("FAIL R2 full got %b expected %b", full, ef); end
    if (sout_n !== en_) begin errors++; $display("FAIL R6 sout_n got %b expected %b", sout_n, en_); end
    if (sout_s !== es) begin errors++; $display("FAIL R7 sout_s got %b expected %b", sout_s, es); end
    if (sout_e !== ee) begin errors++; $display("FAIL R8 sout_e got %b expected %b", sout_e, ee); end
  endtask

  // reference update: R4 clear, R3 hold, R2 stop when full, R9 test/repair keep shifting, R5 source
  task automatic model_edge();
    bit b;
    if (rst) begin
      for (int i = 0; i < W; i++) q[i] = 0;
    end else if (en && (!q[0] || test_mode || repair)) begin
      b = test_mode ? glob_in : ((bottom_row || repair) ? sin_w : sin_s);
      void'(q.pop_front());
      q.push_back(b);
    end
  endtask

  task automatic step();
    #1 compare();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic set_flags(bit t, bit r, bit b, bit tp, bit e);
    test_mode = t; repair = r; bottom_row = b; top_row = tp; entry_pt = e;
  endtask

  task automatic rnd_lines();
    sin_s = $urandom_range(1); sin_n = $urandom_range(1);
    sin_w = $urandom_range(1); glob_in = $urandom_range(1);
  endtask

  task automatic fill_word(bit from_west);
    for (int k = 0; k < 3; k++) begin
      rnd_lines(); if (from_west) sin_w = 0; else sin_s = 0; step();
    end
    for (int k = 0; k < W; k++) begin
      rnd_lines();
      if (from_west) sin_w = (k == 0) ? 1'b1 : 1'($urandom_range(1));
      else sin_s = (k == 0) ? 1'b1 : 1'($urandom_range(1));
      step();
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < W; i++) q.push_back(0);
    rst = 1; en = 1; set_flags(0, 0, 0, 0, 0); rnd_lines();
    @(negedge clk);
    step(); step();
    rst = 0;
    // R5 south source, R1 shift order, R2 stop at head
    fill_word(0);
    // R2 hold and R6/R7/R8 routing with all flag mixes once full
    for (int k = 0; k < 64; k++) begin
      rnd_lines(); set_flags(0, 0, k[0], k[1], k[2]); step();
    end
    // R4 reset then R5 west source in bottom row
    rst = 1; step(); rst = 0;
    set_flags(0, 0, 1, 0, 0); fill_word(1);
    // R3 enable low holds
    en = 0;
    for (int k = 0; k < 10; k++) begin rnd_lines(); set_flags(1, k[0], 0, 0, 0); step(); end
    en = 1;
    // R9 test phase keeps loading from global line even when full
    set_flags(1, 0, 0, 0, 0);
    for (int k = 0; k < 40; k++) begin rnd_lines(); step(); end
    // R9 repair shifts word east through the head, source west (R8)
    set_flags(0, 1, 0, 0, 0);
    for (int k = 0; k < 40; k++) begin rnd_lines(); step(); end
    // mixed random run covering all requirements
    for (int k = 0; k < 2000; k++) begin
      rnd_lines();
      rst = ($urandom_range(99) == 0);
      en = ($urandom_range(3) != 0);
      set_flags($urandom_range(9) == 0, $urandom_range(9) == 0,
                $urandom_range(1), $urandom_range(1), $urandom_range(3) == 0);
      step();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule